// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block holds the pending and active bits of a set of shared interrupts and, for every target processor, chooses the single best interrupt to signal. Shared interrupt IDs start at 32; interrupt index `i` has ID `32 + i`. The per-interrupt configuration arrives as inputs: enable, group-enabled flag, priority, routing mode and affinity. The pending bit follows edges of a level input line. Activate and deactivate commands from the processor side change the state bits.

Each interrupt goes to exactly one target or to none. In affinity mode it goes to the lowest-numbered present target whose affinity value equals its own. In any-target mode it goes to the lowest-numbered present target that accepts any-of-N delivery. Among the candidates of a target, the numerically smallest priority wins, and ties go to the lower ID. The choice is computed combinationally from the current state each cycle and captured in output registers.

Top module: `spi_hp_select`

## Requirements
- R1: An interrupt is a candidate only when it is pending, enabled (`irq_en`), not active, and its group is enabled (`grp_en`).
- R2: Among the candidates routed to one target, the one with the numerically smallest priority is reported.
- R3: When candidates of one target have equal priority, the one with the lower ID is reported.
- R4: A target with no candidate reports `hp_vld`=0, priority 0xFF and ID 0x3FF. The same holds after reset.
- R5: An activate command whose ID matches an interrupt clears its pending bit and sets its active bit. An ID outside the shared range (below 32, or at or above 32+NIRQ) has no effect.
- R6: A deactivate command whose ID matches clears only the active bit. If activate and deactivate name the same ID in one cycle, activate wins.
- R7: `irq_state[2i+1:2i]` reports {active, pending}: 00 inactive, 01 pending, 10 active, 11 active and pending.
- R8: With `route_any[i]`=0, interrupt i goes to the lowest-numbered present target whose `tgt_aff` equals its `irq_aff`.
- R9: With `route_any[i]`=1, interrupt i goes to the lowest-numbered present target whose `tgt_any_ok` bit is set.
- R10: An interrupt that resolves to no present target is not signalled to any target and stays pending.
- R11: A rising edge of `line_in[i]` sets pending. A falling edge clears pending. A line edge takes precedence over an activate in the same cycle.
- R12: State bits update at the clock edge after a command or line edge. Outputs reflect that state one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NIRQ | Level input line per interrupt |
| irq_en | input | NIRQ | Per-interrupt enable |
| grp_en | input | NIRQ | Group of the interrupt is enabled |
| route_any | input | NIRQ | 1: any-target routing, 0: affinity routing |
| irq_prio | input | NIRQ*PW | Priority per interrupt, index i at bits [i*PW +: PW] |
| irq_aff | input | NIRQ*AW | Affinity per interrupt |
| tgt_aff | input | NTGT*AW | Affinity value of each target |
| tgt_present | input | NTGT | Target exists |
| tgt_any_ok | input | NTGT | Target accepts any-target delivery |
| act_req | input | 1 | Activate command strobe |
| act_id | input | IDW | Interrupt ID to activate |
| deact_req | input | 1 | Deactivate command strobe |
| deact_id | input | IDW | Interrupt ID to deactivate |
| irq_state | output | NIRQ*2 | {active, pending} per interrupt |
| hp_vld | output | NTGT | Target has a candidate |
| hp_id | output | NTGT*IDW | Selected ID per target |
| hp_prio | output | NTGT*PW | Selected priority per target |

## Verification
On every cycle, the assertions check the state machine: an activate sets active and drops pending, a deactivate drops active, and a rising line sets pending. They also check that an idle target shows 0xFF and the idle ID, and that no interrupt appears at two targets at once. The winner itself is shown only by the bench scenarios. These cover lowest priority wins, the tie break to the lower ID, masking by enable, group and active bits, affinity versus any-target routing, and absent targets. The bench compares every cycle against a model of the routing and selection rules.

// File: rtl/spi_hp_select.sv
module spi_hp_select #(
  parameter int NIRQ = 8,
  parameter int NTGT = 2,
  parameter int PW   = 8,
  parameter int AW   = 8,
  parameter int IDW  = 10,
  parameter int BASE = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIRQ-1:0]      line_in,
  input  logic [NIRQ-1:0]      irq_en,
  input  logic [NIRQ-1:0]      grp_en,
  input  logic [NIRQ-1:0]      route_any,
  input  logic [NIRQ*PW-1:0]   irq_prio,
  input  logic [NIRQ*AW-1:0]   irq_aff,
  input  logic [NTGT*AW-1:0]   tgt_aff,
  input  logic [NTGT-1:0]      tgt_present,
  input  logic [NTGT-1:0]      tgt_any_ok,
  input  logic                 act_req,
  input  logic [IDW-1:0]       act_id,
  input  logic                 deact_req,
  input  logic [IDW-1:0]       deact_id,
  output logic [NIRQ*2-1:0]    irq_state,
  output logic [NTGT-1:0]      hp_vld,
  output logic [NTGT*IDW-1:0]  hp_id,
  output logic [NTGT*PW-1:0]   hp_prio
);
  localparam logic [PW-1:0]  IDLE_PRIO = {PW{1'b1}};
  localparam logic [IDW-1:0] IDLE_ID   = {IDW{1'b1}};

  logic [NIRQ-1:0] pend, act, line_q, act_hit, deact_hit, elig;
  logic [NTGT-1:0] dest [NIRQ];
  logic            nv [NTGT];
  logic [PW-1:0]   np [NTGT];
  logic [IDW-1:0]  ni [NTGT];

  assign elig = pend & irq_en & ~act & grp_en;

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    assign act_hit[i]   = act_req   && (act_id   == IDW'(BASE + i));
    assign deact_hit[i] = deact_req && (deact_id == IDW'(BASE + i));
    assign irq_state[2*i]   = pend[i];
    assign irq_state[2*i+1] = act[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i]   <= 1'b0;
        act[i]    <= 1'b0;
        line_q[i] <= 1'b0;
      end else begin
        line_q[i] <= line_in[i];
        if (line_in[i] && !line_q[i])      pend[i] <= 1'b1;
        else if (!line_in[i] && line_q[i]) pend[i] <= 1'b0;
        else if (act_hit[i])               pend[i] <= 1'b0;
        if (act_hit[i])        act[i] <= 1'b1;
        else if (deact_hit[i]) act[i] <= 1'b0;
      end
    end

    p_act_sets_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_hit[i] |=> act[i]);
    p_act_drops_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_hit[i] && (line_in[i] == line_q[i]) |=> !pend[i]);
    p_deact_r6: assert property (@(posedge clk) disable iff (!rst_n)
      deact_hit[i] && !act_hit[i] |=> !act[i]);
    p_rise_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
      line_in[i] && !line_q[i] |=> pend[i]);
  end

  always_comb begin
    for (int i = 0; i < NIRQ; i++) begin
      logic found;
      found   = 1'b0;
      dest[i] = '0;
      for (int t = 0; t < NTGT; t++) begin
        if (!found && tgt_present[t] &&
            (route_any[i] ? tgt_any_ok[t]
                          : (tgt_aff[t*AW +: AW] == irq_aff[i*AW +: AW]))) begin
          dest[i][t] = 1'b1;
          found      = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int t = 0; t < NTGT; t++) begin
      nv[t] = 1'b0;
      np[t] = IDLE_PRIO;
      ni[t] = IDLE_ID;
      for (int i = 0; i < NIRQ; i++) begin
        if (elig[i] && dest[i][t] && (!nv[t] || irq_prio[i*PW +: PW] < np[t])) begin
          nv[t] = 1'b1;
          np[t] = irq_prio[i*PW +: PW];
          ni[t] = IDW'(BASE + i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NTGT; t++) begin
      if (!rst_n) begin
        hp_vld[t]              <= 1'b0;
        hp_prio[t*PW +: PW]    <= IDLE_PRIO;
        hp_id[t*IDW +: IDW]    <= IDLE_ID;
      end else begin
        hp_vld[t]              <= nv[t];
        hp_prio[t*PW +: PW]    <= np[t];
        hp_id[t*IDW +: IDW]    <= ni[t];
      end
    end
  end

  for (genvar t = 0; t < NTGT; t++) begin : g_tchk
    p_idle_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hp_vld[t] |-> (hp_prio[t*PW +: PW] == IDLE_PRIO) && (hp_id[t*IDW +: IDW] == IDLE_ID));
    p_present_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hp_vld[t] |-> $past(tgt_present[t]));
    for (genvar u = t + 1; u < NTGT; u++) begin : g_pair
      p_single_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hp_vld[t] && hp_vld[u] |-> hp_id[t*IDW +: IDW] != hp_id[u*IDW +: IDW]);
    end
  end
endmodule

// File: tb/spi_hp_select_test.sv
module spi_hp_select_test;
  localparam int NIRQ = 8, NTGT = 2, PW = 8, AW = 8, IDW = 10, BASE = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NIRQ-1:0] line_in = '0, irq_en = '0, grp_en = '0, route_any = '0;
  logic [NIRQ*PW-1:0] irq_prio = '0;
  logic [NIRQ*AW-1:0] irq_aff = '0;
  logic [NTGT*AW-1:0] tgt_aff = {8'h01, 8'h00};
  logic [NTGT-1:0] tgt_present = '1, tgt_any_ok = '0;
  logic act_req = 1'b0, deact_req = 1'b0;
  logic [IDW-1:0] act_id = '0, deact_id = '0;
  logic [NIRQ*2-1:0] irq_state;
  logic [NTGT-1:0] hp_vld;
  logic [NTGT*IDW-1:0] hp_id;
  logic [NTGT*PW-1:0] hp_prio;

  spi_hp_select #(.NIRQ(NIRQ), .NTGT(NTGT), .PW(PW), .AW(AW), .IDW(IDW), .BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .irq_en(irq_en), .grp_en(grp_en),
    .route_any(route_any), .irq_prio(irq_prio), .irq_aff(irq_aff), .tgt_aff(tgt_aff),
    .tgt_present(tgt_present), .tgt_any_ok(tgt_any_ok), .act_req(act_req), .act_id(act_id),
    .deact_req(deact_req), .deact_id(deact_id), .irq_state(irq_state), .hp_vld(hp_vld),
    .hp_id(hp_id), .hp_prio(hp_prio));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit [NIRQ-1:0] m_pend = '0, m_act = '0, m_lq = '0;
  int e_vld [NTGT], e_id [NTGT], e_pr [NTGT];

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int dest_of(int i);
    for (int t = 0; t < NTGT; t++)
      if (tgt_present[t] && (route_any[i] ? tgt_any_ok[t] :
          (tgt_aff[t*AW +: AW] == irq_aff[i*AW +: AW]))) return t;
    return -1;
  endfunction

  task automatic compute_exp();
    for (int t = 0; t < NTGT; t++) begin
      e_vld[t] = 0; e_pr[t] = 255; e_id[t] = 1023;
      for (int i = 0; i < NIRQ; i++) begin
        int p;
        p = int'(irq_prio[i*PW +: PW]);
        if (m_pend[i] && irq_en[i] && !m_act[i] && grp_en[i] && dest_of(i) == t &&
            (e_vld[t] == 0 || p < e_pr[t])) begin
          e_vld[t] = 1; e_pr[t] = p; e_id[t] = BASE + i;
        end
      end
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < NIRQ; i++) begin
      bit ah, dh;
      ah = act_req && act_id == IDW'(BASE + i);
      dh = deact_req && deact_id == IDW'(BASE + i);
      if (line_in[i] && !m_lq[i]) m_pend[i] = 1'b1;
      else if (!line_in[i] && m_lq[i]) m_pend[i] = 1'b0;
      else if (ah) m_pend[i] = 1'b0;
      if (ah) m_act[i] = 1'b1;
      else if (dh) m_act[i] = 1'b0;
    end
    m_lq = line_in;
  endtask

  task automatic step(string tag);
    int sv [NTGT], si [NTGT], sp [NTGT];
    compute_exp();
    for (int t = 0; t < NTGT; t++) begin sv[t] = e_vld[t]; si[t] = e_id[t]; sp[t] = e_pr[t]; end
    model_step();
    @(posedge clk); @(negedge clk);
    for (int t = 0; t < NTGT; t++)
      chk(tag, {hp_vld[t], hp_prio[t*PW +: PW], hp_id[t*IDW +: IDW]}, {sv[t][0], sp[t][7:0], si[t][9:0]});
    chk({tag, " R7 state"}, int'(irq_state), int'(state_exp()));
  endtask

  function automatic logic [NIRQ*2-1:0] state_exp();
    logic [NIRQ*2-1:0] s;
    for (int i = 0; i < NIRQ; i++) begin s[2*i] = m_pend[i]; s[2*i+1] = m_act[i]; end
    return s;
  endfunction

  task automatic set_irq(int i, int pr, int aff, bit any);
    irq_prio[i*PW +: PW] = PW'(pr);
    irq_aff[i*AW +: AW] = AW'(aff);
    route_any[i] = any;
  endtask

  task automatic pulse_act(int id);
    act_req = 1'b1; act_id = IDW'(id);
    step("R5 activate");
    act_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    for (int t = 0; t < NTGT; t++)
      chk("R4 reset", {hp_vld[t], hp_prio[t*PW +: PW], hp_id[t*IDW +: IDW]}, {1'b0, 8'hFF, 10'h3FF});
    chk("R7 reset state", int'(irq_state), 0);

    irq_en = '1; grp_en = '1;
    for (int i = 0; i < NIRQ; i++) set_irq(i, 8'h80, 0, 1'b0);

    // R11 / R12: line edge sets pending, output follows one edge later
    line_in[0] = 1'b1;
    step("R12 latency");
    chk("R12 idle before select", int'(hp_vld[0]), 0);
    step("R11 rise");
    chk("R11 selected", int'(hp_id[IDW-1:0]), 32);
    line_in[0] = 1'b0;
    step("R11 fall"); step("R11 fall");
    chk("R11 cleared", int'(irq_state[1:0]), 0);

    // R1: masking by enable, group, active
    irq_en[1] = 1'b0; line_in[1] = 1'b1;
    step("R1 disabled"); step("R1 disabled");
    chk("R1 masked", int'(hp_vld[0]), 0);
    irq_en[1] = 1'b1; grp_en[1] = 1'b0;
    step("R1 group off"); step("R1 group off");
    grp_en[1] = 1'b1;
    step("R1 eligible"); step("R1 eligible");

    // R2 / R3: priority, tie break
    set_irq(2, 8'h30, 0, 1'b0); set_irq(5, 8'h10, 0, 1'b0); set_irq(1, 8'h30, 0, 1'b0);
    line_in[2] = 1'b1; line_in[5] = 1'b1;
    step("R2 priority"); step("R2 priority");
    chk("R2 lowest value wins", int'(hp_id[IDW-1:0]), 37);
    set_irq(5, 8'h30, 0, 1'b0);
    step("R3 tie"); step("R3 tie");
    chk("R3 lower ID", int'(hp_id[IDW-1:0]), 33);

    // R5 / R6 / R7
    pulse_act(33); step("R5 after");
    chk("R5 state active", int'(irq_state[3:2]), 2);
    pulse_act(31); pulse_act(40);
    deact_req = 1'b1; deact_id = 10'd33;
    step("R6 deactivate"); deact_req = 1'b0; step("R6 after");
    chk("R6 inactive", int'(irq_state[3:2]), 0);
    pulse_act(34);
    line_in[2] = 1'b0; step("R7 fall");
    line_in[2] = 1'b1; step("R7 rise");
    chk("R7 active and pending", int'(irq_state[5:4]), 3);
    act_req = 1'b1; act_id = 10'd37; deact_req = 1'b1; deact_id = 10'd37;
    step("R6 both"); act_req = 1'b0; deact_req = 1'b0;
    chk("R6 activate wins", int'(irq_state[11:10]), 2);

    // R8 / R9 / R10: routing
    set_irq(3, 8'h05, 1, 1'b0); line_in[3] = 1'b1;
    step("R8 affinity"); step("R8 affinity");
    chk("R8 target 1", int'(hp_id[2*IDW-1:IDW]), 35);
    set_irq(4, 8'h01, 0, 1'b1); tgt_any_ok = 2'b10; line_in[4] = 1'b1;
    step("R9 any"); step("R9 any");
    chk("R9 first accepting", int'(hp_id[2*IDW-1:IDW]), 36);
    tgt_any_ok = 2'b11; step("R9 any"); step("R9 any");
    chk("R9 lowest target", int'(hp_id[IDW-1:0]), 36);
    set_irq(4, 8'h01, 7, 1'b0); set_irq(3, 8'h05, 9, 1'b0);
    step("R10 absent"); step("R10 absent");
    chk("R10 still pending", int'(irq_state[9:8]), 1);
    tgt_present = 2'b10; step("R10 target gone"); step("R10 target gone");
    chk("R10 no output", int'(hp_vld[0]), 0);
    tgt_present = 2'b11;

    // random mix
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NIRQ; i++) begin
        if ($urandom_range(0, 7) == 0) line_in[i] = ~line_in[i];
        if ($urandom_range(0, 31) == 0) begin
          set_irq(i, 8'h20 + 8'($urandom_range(0, 2)) * 8'h10, $urandom_range(0, 2),
                  1'($urandom_range(0, 1)));
          irq_en[i] = ($urandom_range(0, 5) != 0);
          grp_en[i] = ($urandom_range(0, 5) != 0);
        end
      end
      if ($urandom_range(0, 63) == 0) tgt_any_ok = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 127) == 0) tgt_present = 2'($urandom_range(1, 3));
      act_req = ($urandom_range(0, 3) == 0);
      act_id = IDW'($urandom_range(30, 41));
      deact_req = ($urandom_range(0, 3) == 0);
      deact_id = IDW'($urandom_range(30, 41));
      step("R1/R2/R3/R5/R6/R8/R9 random");
    end
    act_req = 1'b0; deact_req = 1'b0;
    finish_run();
  end
endmodule